// File: doc/BRIEF.md
# Programmable GPIO Port Controller

This block is an eight-pin general-purpose I/O port under CPU control over a small register bus. Software sets a direction bit for each pin, writes a port latch that is driven on pins set as outputs, and reads back a value that mixes two sources. Pins set as inputs return their synchronised level. Pins set as outputs return the latch.

Pull-ups are switched per group of four pins, and only on pins that are inputs. Each pin also has a high-sink-strength select. Every pad is controlled through four abstract per-pin signals: output enable, output data, pull-up enable and high drive. A peripheral function can take over any pin as an output. It then drives the pin from its own data, and the direction bit has no effect on that pin.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, latch, pull-up and drive registers read 0. All pad outputs are low.
- R2: Direction bit value 0 selects input mode (pad_oe low). Value 1 selects output mode (pad_oe high) for that pin.
- R3: A write to offset 0x0 updates the port latch on that clock edge, whatever the direction of each pin.
- R4: A read at offset 0x0 returns the synchronised pin level on input-mode bits and the latch on output-mode bits.
- R5: Pin levels reach the read path two clock edges after they are applied.
- R6: An output-mode pin that no peripheral claims drives its latch bit on pad_do.
- R7: Offset 0x2 bit 0 enables pull-ups for pins 3..0 and bit 1 for pins 7..4. The upper read bits are 0. A pull-up is active only on input-mode pins.
- R8: When per_own[i] is 1, pin i has pad_oe high, pad_do equal to per_dat[i] and its pull-up off, and offset 0x0 bit i reads the latch.
- R9: At offset 0x3, bit i set to 1 selects high sink strength on pad_hd[i]. Bit i set to 0 selects normal strength.
- R10: The offsets are 0x0 data, 0x1 direction, 0x2 pull-up and 0x3 drive. Writes take effect on the edge where bus_wr is sampled high. Reads are combinational from bus_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Sampled pad levels (asynchronous) |
| per_own | input | 8 | Peripheral output claim per pin |
| per_dat | input | 8 | Peripheral output data per pin |
| pad_oe | output | 8 | Per-pin output enable |
| pad_do | output | 8 | Per-pin output data |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_hd | output | 8 | Per-pin high sink strength |

## Verification
Five properties are checked on every cycle:
- a data write lands in the latch;
- the latch holds when it is not written;
- a direction write raises pad_oe;
- a drive write reaches pad_hd;
- input-mode bits of a data read match the pin level from two edges earlier.

The bench's scenarios cover the rest: the reset values, the nibble mapping of the pull-up bits, the pull-up blocking on outputs and claimed pins, and the exact cycle in which a changed pin level first appears in a read. The bench also compares every pad output and every read against its own register model, under random traffic and override patterns.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W   = 8,
  parameter int GRP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] per_own,
  input  logic [W-1:0] per_dat,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_hd
);
  localparam int NG = W / GRP;

  logic [W-1:0]  lat_r, dir_r, drv_r, sy1, sy2, pu_exp;
  logic [NG-1:0] pu_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_r <= '0;
      dir_r <= '0;
      pu_r  <= '0;
      drv_r <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        2'd0: lat_r <= bus_wdata;
        2'd1: dir_r <= bus_wdata;
        2'd2: pu_r  <= bus_wdata[NG-1:0];
        default: drv_r <= bus_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= pin_in;
      sy2 <= sy1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pu
    assign pu_exp[i] = pu_r[i / GRP];
  end

  wire [W-1:0] drive_m = dir_r | per_own;

  assign pad_oe = drive_m;
  assign pad_do = (per_own & per_dat) | (~per_own & lat_r);
  assign pad_pu = pu_exp & ~drive_m;
  assign pad_hd = drv_r;

  always_comb begin
    case (bus_addr)
      2'd0: bus_rdata = (drive_m & lat_r) | (~drive_m & sy2);
      2'd1: bus_rdata = dir_r;
      2'd2: bus_rdata = W'(pu_r);
      default: bus_rdata = drv_r;
    endcase
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> lat_r == $past(bus_wdata)); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd0) |=> $stable(lat_r)); // R10
  AST_DIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> (pad_oe & $past(bus_wdata)) == $past(bus_wdata)); // R2
  AST_DRIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> pad_hd == $past(bus_wdata)); // R9
  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && bus_addr == 2'd0) |->
      ((bus_rdata ^ $past(pin_in, 2)) & ~(dir_r | per_own)) == '0); // R5
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 0;
  logic [W-1:0] bus_wdata = '0, pin_in = '0, per_own = '0, per_dat = '0;
  logic [W-1:0] bus_rdata, pad_oe, pad_do, pad_pu, pad_hd;

  gpio_port u_gpio_port (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [W-1:0] m_lat, m_dir, m_drv, m_s1, m_s2;
  logic [1:0] m_pu;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] e_read(logic [1:0] a);
    logic [W-1:0] drv = m_dir | per_own;
    case (a)
      2'd0: return (drv & m_lat) | (~drv & m_s2);
      2'd1: return m_dir;
      2'd2: return {6'b0, m_pu};
      default: return m_drv;
    endcase
  endfunction

  function automatic logic [W-1:0] e_pu();
    return {{4{m_pu[1]}}, {4{m_pu[0]}}} & ~(m_dir | per_own);
  endfunction

  task automatic check_all(string tag);
    #1;
    chk({tag, " R4/R10 rdata"}, bus_rdata, e_read(bus_addr));
    chk({tag, " R2/R8 oe"}, pad_oe, m_dir | per_own);
    chk({tag, " R6/R8 do"}, pad_do, (per_own & per_dat) | (~per_own & m_lat));
    chk({tag, " R7 pu"}, pad_pu, e_pu());
    chk({tag, " R9 hd"}, pad_hd, m_drv);
  endtask

  task automatic cyc();
    @(posedge clk);
    if (bus_wr)
      case (bus_addr)
        2'd0: m_lat = bus_wdata;
        2'd1: m_dir = bus_wdata;
        2'd2: m_pu  = bus_wdata[1:0];
        default: m_drv = bus_wdata;
      endcase
    m_s2 = m_s1;
    m_s1 = pin_in;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_lat = 0; m_dir = 0; m_drv = 0; m_pu = 0; m_s1 = 0; m_s2 = 0;
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); #1;
      chk("R1 reset read", bus_rdata, a == 0 ? 8'h00 : 8'h00);
    end
    chk("R1 oe", pad_oe, 0); chk("R1 do", pad_do, 0);
    chk("R1 pu", pad_pu, 0); chk("R1 hd", pad_hd, 0);
    rst_n = 1;
    cyc();

    // R3 latch written while input, then visible once output
    wr(2'd0, 8'h3C);
    bus_addr = 2'd0; #1;
    chk("R3 input read shows pins", bus_rdata, 8'h00);
    wr(2'd1, 8'hFF);
    #1; chk("R3 latch kept while input", pad_do, 8'h3C);
    bus_addr = 2'd0; #1; chk("R4 output read latch", bus_rdata, 8'h3C);
    wr(2'd1, 8'h00);

    // R5 two-edge latency
    pin_in = 8'hA5; cyc(); cyc(); cyc();
    pin_in = 8'h5A; bus_addr = 2'd0;
    cyc(); #1; chk("R5 one edge old", bus_rdata, 8'hA5);
    cyc(); #1; chk("R5 two edges new", bus_rdata, 8'h5A);

    // R7 nibble mapping and input-only
    wr(2'd2, 8'hFD); #1; chk("R7 low nibble", pad_pu, 8'h0F);
    bus_addr = 2'd2; #1; chk("R7 upper read bits zero", bus_rdata, 8'h01);
    wr(2'd2, 8'h02); #1; chk("R7 high nibble", pad_pu, 8'hF0);
    wr(2'd1, 8'h30); #1; chk("R7 output blocks pu", pad_pu, 8'hC0);
    per_own = 8'h80; per_dat = 8'h80; #1;
    chk("R8 override blocks pu", pad_pu, 8'h40);
    chk("R8 override oe", pad_oe, 8'hB0);
    chk("R8 override data", pad_do, 8'h80 | (8'h3C & 8'h7F));
    bus_addr = 2'd0; #1; chk("R8 override read latch", bus_rdata, (8'hB0 & 8'h3C) | (8'h4F & 8'h5A));
    per_own = 0; per_dat = 0;
    wr(2'd3, 8'h81); #1; chk("R9 high drive", pad_hd, 8'h81);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      pin_in = 8'($urandom);
      per_own = 8'($urandom) & 8'($urandom) & 8'($urandom);
      per_dat = 8'($urandom);
      bus_addr = 2'($urandom);
      bus_wdata = 8'($urandom);
      bus_wr = ($urandom % 3) == 0;
      check_all("rand");
      cyc();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule